// File: doc/BRIEF.md
# I2C Slave Address Matcher with Don't-Care Mask

This block covers the addressing part of an I2C target device. It watches SCL and SDA levels that are already synchronised to the system clock. It finds START, repeated START and STOP conditions and collects the address byte, or the two address bytes in 10-bit mode. It compares what it received with a programmed address. Any bit position selected in a five-bit mask takes no part in the compare, so a single target answers to a whole group of addresses.

On a hit the block pulls SDA low through an open-drain enable for the acknowledge slot. When the last address byte has been acknowledged it raises a one-cycle interrupt. It keeps the received byte so that software can tell which member of the group was addressed. The bus behaves the same way whether or not any mask bit is set. After the address phase the block stays silent until the next START.

Top module: `i2c_mask_addr_match`

## Requirements
- R1: After reset, sda_pull_o and match_irq_o are 0 and rx_addr_o is 00h.
- R2: A START is SDA falling while SCL is high. It begins a new address phase from any state, which makes it work as a repeated START. A STOP is SDA rising while SCL is high. It returns the block to idle, so bits clocked in afterwards without a new START are not acknowledged.
- R3: In 7-bit mode (mode_10b_i=0), received bits 7:1 are compared with addr_i bits 7:1. Received bit 0 is the R/W bit and is never compared. For n from 1 to 5, mask_i[n-1]=1 removes bit n from the compare. Bits 7 and 6 are always compared. With addr_i=A0h and mask_i=00111b, exactly eight of the 128 address values are acknowledged: A0h, A2h, ..., AEh, each with either R/W value.
- R4: In 10-bit mode, the first byte is acknowledged only when its bits 7:3 equal 11110b and its bits 2:1 equal addr_hi_i. Bit 0 is ignored and the mask has no effect on this byte.
- R5: In 10-bit mode, the second byte is compared over all eight bits with addr_i. For n from 2 to 5, mask_i[n-1]=1 removes bit n. mask_i[0]=1 removes bits 1 and 0 together. Bits 7 and 6 are always compared. With addr_i=A0h and mask_i=00111b, exactly the sixteen low bytes A0h to AFh are acknowledged.
- R6: On a hit, sda_pull_o rises in the clock after the SCL falling edge that ends the eighth bit. It falls in the clock after the SCL falling edge that ends the ninth bit.
- R7: On a miss, sda_pull_o stays 0, no interrupt is raised, and later bytes are ignored until the next START.
- R8: match_irq_o is a single-cycle pulse. It comes in the clock after the SCL falling edge that ends the acknowledge of the final address byte: the only byte in 7-bit mode, or the second byte in 10-bit mode. An acknowledged 10-bit header alone gives no pulse.
- R9: rx_addr_o takes the complete final address byte, including bit 0, at the moment the acknowledge starts. It holds that value otherwise.
- R10: With mask_i=0, exactly one 7-bit address (two byte values, differing in R/W) is acknowledged, with the same timing as a masked hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| mode_10b_i | input | 1 | 1 selects 10-bit addressing |
| addr_i | input | 8 | 7-bit address in bits 7:1, or the 10-bit low byte |
| addr_hi_i | input | 2 | Address bits 9:8 for 10-bit mode |
| mask_i | input | 5 | Don't-care mask; mask_i[k] is mask bit k+1 |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| match_irq_o | output | 1 | One-cycle pulse when the address phase ends in a hit |
| rx_addr_o | output | 8 | Last acknowledged final address byte |

## Verification
A wrong compare mask or a wrong bit mapping shows up at the acknowledge of the byte concerned. The bench sees it within one clock of the eighth SCL falling edge, as an extra or missing SDA pull. It also sees it in the total number of acknowledged addresses over a full sweep. A bit counter that is off by one or a stuck phase state shifts or extends the pull window, or moves the interrupt away from the clock after the ninth falling edge. A missed START or STOP gives an acknowledge where the bench expects silence, on the very next byte.

// File: rtl/i2c_mask_addr_match.sv
module i2c_mask_addr_match #(
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              mode_10b_i,
  input  logic [7:0]        addr_i,
  input  logic [1:0]        addr_hi_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              sda_pull_o,
  output logic              match_irq_o,
  output logic [7:0]        rx_addr_o
);
  localparam int BITS = 8;
  localparam logic [4:0] HDR_TAG = 5'b11110;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_ACK, S_IGN} st_t;

  st_t        st;
  logic       scl_q, sda_q, second, final_q;
  logic [3:0] cnt;
  logic [7:0] sr;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;

  logic [7:0] care7, care10;
  assign care7  = {2'b11, ~mask_i[4:0], 1'b0};
  assign care10 = {2'b11, ~mask_i[4:1], ~mask_i[0], ~mask_i[0]};

  logic hdr_phase, hdr_ok, low_ok, hit;
  assign hdr_phase = mode_10b_i & ~second;
  assign hdr_ok    = (sr[7:3] == HDR_TAG) && (sr[2:1] == addr_hi_i);
  assign low_ok    = ((sr ^ addr_i) & (mode_10b_i ? care10 : care7)) == 8'h00;
  assign hit       = hdr_phase ? hdr_ok : low_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      cnt         <= '0;
      sr          <= '0;
      second      <= 1'b0;
      final_q     <= 1'b0;
      sda_pull_o  <= 1'b0;
      match_irq_o <= 1'b0;
      rx_addr_o   <= '0;
    end else begin
      scl_q       <= scl_i;
      sda_q       <= sda_i;
      match_irq_o <= 1'b0;
      if (start_c) begin
        st         <= S_SHIFT;
        cnt        <= '0;
        second     <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        st         <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (st)
          S_SHIFT: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS) begin
              if (hit) begin
                st         <= S_ACK;
                sda_pull_o <= 1'b1;
                final_q    <= ~hdr_phase;
                if (!hdr_phase) rx_addr_o <= sr;
              end else begin
                st <= S_IGN;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              if (final_q) begin
                match_irq_o <= 1'b1;
                st          <= S_IGN;
              end else begin
                st     <= S_SHIFT;
                cnt    <= '0;
                second <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_pull_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> st == S_ACK);
  assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !start_c) |=> (st == S_IDLE && !sda_pull_o));
  assert_ign_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN && !start_c) |=> !sda_pull_o);
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq_o |=> !match_irq_o);
  assert_irq_ends_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq_o |-> ($fell(sda_pull_o) && $past(final_q)));
  assert_rx_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_addr_o) |-> $rose(sda_pull_o));
endmodule

// File: tb/test_i2c_mask_addr_match.sv
module test_i2c_mask_addr_match;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic mode10 = 1'b0;
  logic [7:0] addr = 8'hA0;
  logic [1:0] addr_hi = 2'b10;
  logic [4:0] mask = 5'b00111;
  logic sda_pull, irq;
  logic [7:0] rx_addr;
  logic sda_bus;
  assign sda_bus = sda_drv & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mask_addr_match i_i2c_mask_addr_match (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .mode_10b_i(mode10), .addr_i(addr), .addr_hi_i(addr_hi), .mask_i(mask),
    .sda_pull_o(sda_pull), .match_irq_o(irq), .rx_addr_o(rx_addr));

  int tests = 0, fails = 0;
  logic chk_en = 1'b0;
  logic exp_pull = 1'b0, exp_irq = 1'b0;
  logic [7:0] exp_rx = 8'h00;
  string cur_req = "R1";

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (chk_en) begin
      check({cur_req, "/R6 sda_pull"}, sda_pull, exp_pull);
      check({cur_req, "/R8 irq"}, irq, exp_irq);
      check({cur_req, "/R9 rx_addr"}, rx_addr, exp_rx);
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit ref7(logic [7:0] rx);
    int dc = 0;
    for (int n = 1; n <= 5; n++) if (mask[n-1]) dc += (1 << n);
    return ((int'(rx) | dc) & 'hFE) == ((int'(addr) | dc) & 'hFE);
  endfunction

  function automatic bit ref10(logic [7:0] rx);
    int dc = mask[0] ? 3 : 0;
    for (int n = 2; n <= 5; n++) if (mask[n-1]) dc += (1 << n);
    return (int'(rx) | dc) == (int'(addr) | dc);
  endfunction

  function automatic bit refhdr(logic [7:0] rx);
    return (int'(rx) / 8 == 'h1E) && ((int'(rx) / 2) % 4 == int'(addr_hi));
  endfunction

  task automatic do_start;
    sda_drv = 1'b1; tick(2);
    scl = 1'b1; tick(4);
    sda_drv = 1'b0; tick(4);
    scl = 1'b0; tick(2);
  endtask

  task automatic do_stop;
    sda_drv = 1'b0; tick(2);
    scl = 1'b1; tick(4);
    sda_drv = 1'b1; tick(4);
  endtask

  task automatic send_bits(logic [7:0] b, int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_drv = b[i]; tick(2);
      scl = 1'b1; tick(4);
      scl = 1'b0; tick(2);
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit ack, bit fin);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(2);
      scl = 1'b1; tick(4);
      scl = 1'b0;
      if (i == 0) begin
        exp_pull = ack;
        if (ack && fin) exp_rx = b;
      end
      tick(2);
    end
    sda_drv = 1'b1; tick(2);
    scl = 1'b1; tick(4);
    scl = 1'b0;
    exp_pull = 1'b0;
    exp_irq = ack && fin;
    tick(1);
    exp_irq = 1'b0;
    tick(1);
  endtask

  task automatic tx7(logic [7:0] b, output bit acked);
    acked = ref7(b);
    do_start();
    send_byte(b, acked, 1'b1);
    do_stop();
  endtask

  task automatic tx10(logic [7:0] hdr, logic [7:0] low, output bit acked);
    bit h = refhdr(hdr);
    acked = h && ref10(low);
    do_start();
    send_byte(hdr, h, 1'b0);
    send_byte(low, acked, 1'b1);
    do_stop();
  endtask

  initial begin
    int cnt;
    bit a;
    tick(3);
    check("R1 pull", sda_pull, 0);
    check("R1 irq", irq, 0);
    check("R1 rx_addr", rx_addr, 0);
    rst_n = 1'b1;
    tick(2);
    chk_en = 1'b1;

    cur_req = "R3";
    cnt = 0;
    for (int v = 0; v < 256; v += 2) begin tx7(8'(v), a); cnt += int'(a); end
    check("R3 ack count 7-bit masked", cnt, 8);
    tx7(8'hAD, a);
    check("R3 rw bit ignored AD", int'(a), 1);
    check("R3 rx_addr keeps rw bit", rx_addr, 8'hAD);

    cur_req = "R10";
    mask = 5'b00000; addr = 8'h5A;
    cnt = 0;
    for (int v = 0; v < 256; v++) begin tx7(8'(v), a); cnt += int'(a); end
    check("R10 ack count unmasked", cnt, 2);

    cur_req = "R5";
    mode10 = 1'b1; addr = 8'hA0; addr_hi = 2'b10; mask = 5'b00111;
    cnt = 0;
    for (int v = 0; v < 256; v++) begin tx10(8'hF4, 8'(v), a); cnt += int'(a); end
    check("R5 ack count 10-bit masked", cnt, 16);
    mask = 5'b00001;
    cnt = 0;
    for (int v = 'h98; v < 'hA8; v++) begin tx10(8'hF5, 8'(v), a); cnt += int'(a); end
    check("R5 mask bit1 covers bits 1:0", cnt, 4);

    cur_req = "R4";
    tx10(8'hF2, 8'hA0, a);
    check("R4 wrong A9:A8 rejected", int'(a), 0);
    tx10(8'hFC, 8'hA0, a);
    check("R4 wrong tag rejected", int'(a), 0);
    mask = 5'b11111;
    tx10(8'hF6, 8'hA0, a);
    check("R4 mask does not reach header", int'(a), 0);
    mask = 5'b00111;

    cur_req = "R7";
    mode10 = 1'b0;
    do_start();
    send_byte(8'h12, 1'b0, 1'b1);
    send_byte(8'hA0, 1'b0, 1'b1);
    do_stop();
    check("R7 ignored after miss", rx_addr, exp_rx);

    cur_req = "R2";
    do_start();
    send_bits(8'hA0, 4);
    do_start();
    send_byte(8'hA4, 1'b1, 1'b1);
    do_stop();
    check("R2 repeated start then hit", rx_addr, 8'hA4);
    do_start();
    send_bits(8'hA0, 5);
    do_stop();
    scl = 1'b0; tick(2);
    send_byte(8'hA2, 1'b0, 1'b1);
    scl = 1'b1; tick(2);
    do_stop();
    check("R2 no ack without start", rx_addr, 8'hA4);

    tick(4);
    summary();
  end
endmodule